// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM that shares one data bus for reads and writes. The host raises a request with a write flag, a 15-bit word address and, for writes, an 8-bit value. The controller then plays out the memory's control pattern on its active-low chip select, write enable and output enable lines. It finishes with a one-cycle done strobe, which for reads carries the registered data word.

Every interval the memory needs is given as a nanosecond parameter. Elaboration turns each one into a whole number of clock cycles, always rounding up, so the same code meets the 55 ns speed grade at any clock period. Writes are controlled by write enable, and output enable stays high through the whole write. The controller turns on its own data drivers only after write enable has been low long enough for the memory to release the bus. Reads keep write enable high and lower output enable. The data word is sampled once both the address-access time and the output-enable access time have elapsed.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, write enable and output enable are all 1, the data drive enable is 0, ready is 1 and done is 0.
- R2: A request is taken only when ready is 1. Ready is 0 from the cycle after acceptance until the controller is idle again. A request raised while ready is 0 has no effect on the memory contents.
- R3: A write lowers chip select first and lowers write enable no earlier than the next cycle. Write enable is low only while chip select is low. Output enable stays 1 for the whole write.
- R4: The data drive enable rises only after write enable has been low for at least ceil(20 ns / clock) cycles. It is never 1 while output enable is 0.
- R5: Written data is driven for at least ceil(25 ns / clock) cycles before write enable rises. The write pulse lasts at least ceil(40 ns / clock) cycles. The drivers stay on for at least one cycle after write enable rises.
- R6: The memory address does not change during any cycle in which chip select is low and was low in the previous cycle.
- R7: A read keeps write enable 1 and output enable 0 for the access. Data is sampled at least ceil(55 ns / clock) cycles after the address was applied and at least ceil(30 ns / clock) cycles after output enable fell. Output enable and write enable are never both 0.
- R8: Done is 1 for exactly one cycle per accepted request. With a 10 ns clock, done appears 7 rising edges after the accepting edge for a write and 6 for a read. Read data is valid on the host data output while done is 1.
- R9: Accesses to word address 0x0000 and 0x7FFF store and return their data like any other address.
- R10: A read returns the value most recently written to that address. A write to one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle and able to take a request |
| host_done | output | 1 | One-cycle completion strobe |
| host_rdata | output | 8 | Registered read data |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dout | output | 8 | Data towards the memory |
| mem_din | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
The bench memory model works in real time. It returns a poison byte until the 55 ns address and 30 ns output-enable limits have passed. It stores a corruption byte when data was not stable 25 ns before write enable rose, and it counts a fault whenever drivers turn on within 20 ns of write enable falling. Any shortened interval therefore shows up as a wrong read-back value. The vector walk mixes writes and reads to different addresses, the two end addresses, an overwrite of one word, and back-to-back reads of a word whose address does not change. These patterns separate address-decode faults, lost or stale writes, and captures that depend on an address change. A directed case raises a second request while a write is in progress; only a controller that ignores it keeps the victim word intact.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WR_GAP,
        ST_WR_DRV,
        ST_WR_HOLD,
        ST_RD_ACC,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // Whole cycles covering a nanosecond interval, never fewer than one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t state_pins(input ctl_state_e s);
        pin_ctl_t p;
        p = PINS_OFF;
        case (s)
            ST_SETUP:   p.cs_n = 1'b0;
            ST_WR_GAP:  begin p.cs_n = 1'b0; p.we_n = 1'b0; end
            ST_WR_DRV:  begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
            ST_WR_HOLD: begin p.cs_n = 1'b0; p.drive = 1'b1; end
            ST_RD_ACC:  begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            default:    p = PINS_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int SU_C   = 1,
    parameter int REL_C  = 2,
    parameter int DRV_C  = 3,
    parameter int HOLD_C = 1,
    parameter int ACC_C  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       wr,
    output ctl_state_e state_q_o,
    output ctl_state_e state_d_o,
    output logic       accept_o,
    output logic       capture_o
);
    localparam int MAX_D = max2(max2(SU_C, REL_C), max2(max2(DRV_C, HOLD_C), ACC_C));
    localparam int CNT_W = (MAX_D > 2) ? $clog2(MAX_D) : 1;

    ctl_state_e state_q, state_d;
    logic       wr_q;
    logic       tmr_zero;
    logic       tmr_load;
    logic [CNT_W-1:0] tmr_val;

    function automatic logic [CNT_W-1:0] dur_m1(input ctl_state_e s);
        int d;
        case (s)
            ST_SETUP:   d = SU_C;
            ST_WR_GAP:  d = REL_C;
            ST_WR_DRV:  d = DRV_C;
            ST_WR_HOLD: d = HOLD_C;
            ST_RD_ACC:  d = ACC_C;
            default:    d = 1;
        endcase
        return CNT_W'(d - 1);
    endfunction

    assign accept_o  = (state_q == ST_IDLE) && req;
    assign capture_o = (state_q == ST_RD_ACC) && tmr_zero;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req)      state_d = ST_SETUP;
            ST_SETUP:   if (tmr_zero) state_d = wr_q ? ST_WR_GAP : ST_RD_ACC;
            ST_WR_GAP:  if (tmr_zero) state_d = ST_WR_DRV;
            ST_WR_DRV:  if (tmr_zero) state_d = ST_WR_HOLD;
            ST_WR_HOLD: if (tmr_zero) state_d = ST_DONE;
            ST_RD_ACC:  if (tmr_zero) state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = dur_m1(state_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o)
                wr_q <= wr;
        end
    end

    sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign state_q_o = state_q;
    assign state_d_o = state_d;

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> (state_q == ST_SETUP)); // R2
    AST_BUSY_NO_SETUP: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_SETUP) |=> (state_q != ST_SETUP)); // R2
endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] mem_din,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            wdata_o <= '0;
            rdata_o <= '0;
        end else begin
            if (accept) begin
                addr_o  <= host_addr;
                wdata_o <= host_wdata;
            end
            if (capture)
                rdata_o <= mem_din;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 0,
    parameter int T_WDIS_NS = 20,
    parameter int T_DS_NS   = 25,
    parameter int T_DH_NS   = 0,
    parameter int T_WP_NS   = 40,
    parameter int T_WC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dq_oe
);
    localparam int SU_C   = ns2cyc(T_AS_NS, CLK_NS);
    localparam int REL_C  = ns2cyc(T_WDIS_NS, CLK_NS);
    localparam int DRV_C  = max2(ns2cyc(T_DS_NS, CLK_NS), ns2cyc(T_WP_NS, CLK_NS) - REL_C);
    localparam int HOLD_C = max2(ns2cyc(T_DH_NS, CLK_NS),
                                 ns2cyc(T_WC_NS, CLK_NS) - SU_C - REL_C - DRV_C);
    localparam int ACC_C  = max2(ns2cyc(T_OE_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS) - SU_C);

    ctl_state_e state_q, state_d;
    logic       accept, capture;
    pin_ctl_t   pins_q;

    sram_ctrl_seq #(
        .SU_C(SU_C), .REL_C(REL_C), .DRV_C(DRV_C), .HOLD_C(HOLD_C), .ACC_C(ACC_C)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req       (host_req),
        .wr        (host_wr),
        .state_q_o (state_q),
        .state_d_o (state_d),
        .accept_o  (accept),
        .capture_o (capture)
    );

    sram_ctrl_dpath #(.AW(ADDR_W), .DW(DATA_W)) dpath_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_din    (mem_din),
        .addr_o     (mem_addr),
        .wdata_o    (mem_dout),
        .rdata_o    (host_rdata)
    );

    // Controls come straight from flops so the memory never sees decode glitches.
    always_ff @(posedge clk) begin
        if (rst) pins_q <= PINS_OFF;
        else     pins_q <= state_pins(state_d);
    end

    assign mem_cs_n   = pins_q.cs_n;
    assign mem_we_n   = pins_q.we_n;
    assign mem_oe_n   = pins_q.oe_n;
    assign mem_dq_oe  = pins_q.drive;
    assign host_ready = (state_q == ST_IDLE);
    assign host_done  = (state_q == ST_DONE);

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n); // R3
    AST_WE_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_cs_n)); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R4
    AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n))); // R4
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !mem_cs_n) |-> mem_dq_oe); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R6
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done); // R8
endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/100ps
module sram_async_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R8: latency in rising edges after the accepting edge
    localparam int E_SU  = cyc(0);
    localparam int E_REL = cyc(20);
    localparam int E_DRV = mx(cyc(25), cyc(40) - E_REL);
    localparam int E_HLD = mx(cyc(0), cyc(55) - E_SU - E_REL - E_DRV);
    localparam int WR_LAT = E_SU + E_REL + E_DRV + E_HLD;
    localparam int RD_LAT = E_SU + mx(cyc(30), cyc(55) - E_SU);

    // vector: {wr, addr[14:0], data[7:0]}; for reads data is the expected value
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 15'h0000, 8'h11},
        {1'b1, 15'h7FFF, 8'hC3},
        {1'b1, 15'h1234, 8'h5A},
        {1'b1, 15'h4321, 8'h96},
        {1'b0, 15'h0000, 8'h11},
        {1'b0, 15'h7FFF, 8'hC3},
        {1'b0, 15'h1234, 8'h5A},
        {1'b1, 15'h1234, 8'h0F},
        {1'b0, 15'h1234, 8'h0F},
        {1'b0, 15'h1234, 8'h0F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_done;
    logic [7:0]  host_rdata;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = 8'hA5;

    int n_chk = 0;
    int n_err = 0;
    int bus_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_done(host_done),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- memory model with real-time limits ----------------
    logic [7:0] mem [int];
    realtime t_addr = 0, t_oe = 0, t_wef = 0, t_dv = 0;

    always @(mem_addr)           t_addr = $realtime;
    always @(negedge mem_oe_n)   t_oe   = $realtime;
    always @(negedge mem_we_n)   t_wef  = $realtime;
    always @(mem_dout or posedge mem_dq_oe) t_dv = $realtime;

    always @(posedge mem_dq_oe)
        if (mem_we_n || ($realtime - t_wef < 20.0)) bus_err++;

    always @(negedge clk)
        if (!rst && !mem_oe_n && mem_dq_oe) bus_err++;

    always @(posedge mem_we_n)
        if (mem_cs_n === 1'b0) begin
            if (mem_dq_oe && ($realtime - t_dv >= 25.0))
                mem[int'(mem_addr)] = mem_dout;
            else
                mem[int'(mem_addr)] = 8'hEE;
        end

    initial begin
        #0.5;
        forever begin
            if (mem_cs_n === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b0 &&
                ($realtime - t_addr >= 55.0) && ($realtime - t_oe >= 30.0))
                mem_din = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
            else
                mem_din = 8'hA5;
            #1;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [14:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_done && lat < 50) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        rd = host_rdata;
        @(negedge clk);
        check("R8 done lasts one cycle", {31'd0, host_done}, 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        logic [7:0] rd;
        int lat;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 cs_n in reset", {31'd0, mem_cs_n}, 32'd1);
        check("R1 we_n in reset", {31'd0, mem_we_n}, 32'd1);
        check("R1 oe_n in reset", {31'd0, mem_oe_n}, 32'd1);
        check("R1 drive in reset", {31'd0, mem_dq_oe}, 32'd0);
        check("R1 ready in reset", {31'd0, host_ready}, 32'd1);
        check("R1 done in reset", {31'd0, host_done}, 32'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 controls idle after reset", {28'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'hE);

        // table walk: R9 end addresses, R10 write/readback and overwrite
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][23], VEC[i][22:8], VEC[i][7:0], rd, lat);
            if (VEC[i][23]) begin
                check("R8 write latency", lat, WR_LAT);
            end else begin
                check("R8 read latency", lat, RD_LAT);
                check("R10 R9 R7 read data", {24'd0, rd}, {24'd0, VEC[i][7:0]});
            end
        end

        // R10: neighbour untouched by writes elsewhere
        access(1'b0, 15'h4321, 8'h00, rd, lat);
        check("R10 other address unchanged", {24'd0, rd}, 32'h96);

        // R2: request during a busy write is ignored
        access(1'b1, 15'h0555, 8'h3C, rd, lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 15'h0100; host_wdata = 8'h77;
        @(posedge clk); @(negedge clk);
        host_addr = 15'h0555; host_wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        check("R2 ready low while busy", {31'd0, host_ready}, 32'd0);
        host_req = 1'b1;
        @(posedge clk); @(negedge clk);
        host_req = 1'b0;
        while (!host_done) begin @(posedge clk); @(negedge clk); end
        @(negedge clk);
        check("R2 ready back after done", {31'd0, host_ready}, 32'd1);
        access(1'b0, 15'h0555, 8'h00, rd, lat);
        check("R2 busy request ignored", {24'd0, rd}, 32'h3C);
        access(1'b0, 15'h0100, 8'h00, rd, lat);
        check("R2 accepted write landed", {24'd0, rd}, 32'h77);

        // R4 R5 R7: memory model saw no bus fault or early drive
        check("R4 R5 bus contention events", bus_err, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule